// File: doc/BRIEF.md
# FIFO Level Monitor with DMA Request Generation

This block buffers 16-bit data words between a host bus and a memory-card data path in a 32-deep first-in first-out store. It watches the store's fill count against two programmable levels. When data flows from the card to the host, a fill count above the almost-full level asks for service. When data flows from the host to the card, a fill count below the almost-empty level asks for service. For each direction a configuration bit decides whether that service request goes out as a DMA request line or as a status flag that software polls.

A small state machine evaluates the service condition once per clock from registered inputs. Its state register drives the four service outputs directly, so the requests cannot glitch. There are seven states:
- `LV_IDLE`: no transfer is active and the store is empty.
- `LV_RX_WAIT`: card-to-host direction, level not crossed.
- `LV_RX_DMA`: card-to-host, almost-full crossed, DMA enabled.
- `LV_RX_FLAG`: card-to-host, almost-full crossed, polled mode.
- `LV_TX_WAIT`: host-to-card direction, level not crossed.
- `LV_TX_DMA`: host-to-card, almost-empty crossed, DMA enabled.
- `LV_TX_FLAG`: host-to-card, almost-empty crossed, polled mode.

Each cycle the machine moves to the one state selected by the current condition, from any state. The transitions are `to_idle`, taken when no transfer is active and the store is empty. Otherwise one of `to_rx_*` is taken when the direction bit is 1, or one of `to_tx_*` when it is 0.

The neighbouring status register places the almost-full flag at bit 10 and the almost-empty flag at bit 11.

Top module: `fifo_level_dreq`

## Requirements
- R1: Accepted words leave `pop_data` in the order they were pushed. Read and write pointers wrap modulo 32. `pop_data` shows the head word combinationally.
- R2: `fill_count` ranges over 0..32 and changes at the clock edge where a push or pop is accepted. A push and a pop accepted together leave it unchanged.
- R3: Configuration fields and reset values:
  - A `cfg_wr` pulse loads `cfg_data`.
  - Field positions: bit 15 is receive DMA enable, bits 12:8 are the almost-full level, bit 7 is transmit DMA enable, bits 4:0 are the almost-empty level. All other bits are ignored.
  - After reset both enables are 0, the almost-full level is 31 and the almost-empty level is 0.
- R4: With `dir_rx`=1 and the channel not idle, a fill count above the almost-full level with receive DMA enabled gives `rx_dreq`=1 and `lvl_full_flag`=0.
- R5: In that same condition with receive DMA disabled, `lvl_full_flag`=1 and `rx_dreq`=0. When the count is not above the level, both are 0.
- R6: With `dir_rx`=0 and the channel not idle, a fill count below the almost-empty level with transmit DMA enabled gives `tx_dreq`=1 and `lvl_empty_flag`=0.
- R7: In that same condition with transmit DMA disabled, `lvl_empty_flag`=1 and `tx_dreq`=0. When the count is not below the level, both are 0.
- R8: When `xfer_active`=0 and the fill count is 0, all four service outputs are 0.
- R9: A push while the store holds 32 words is dropped. The count stays at 32 and the stored words are unchanged.
- R10: A pop while the store is empty is handled as follows:
  - `pop_data` shows the word at the read pointer (stale data, 0 after reset).
  - The pointers and the count do not change.
  - `underrun` is 1 in that same cycle.
- R11: The four service outputs are registered. They reflect the fill count, configuration, direction and active flag as they stood before the previous clock edge, and at most one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the buffer configuration |
| cfg_data | input | 16 | Buffer configuration word |
| dir_rx | input | 1 | 1 = card-to-host, 0 = host-to-card |
| xfer_active | input | 1 | A data transfer is in progress |
| push | input | 1 | Write strobe into the store |
| push_data | input | 16 | Word to write |
| pop | input | 1 | Read strobe from the store |
| pop_data | output | 16 | Head word of the store |
| underrun | output | 1 | Pop attempted while empty |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |
| lvl_full_flag | output | 1 | Polled almost-full flag (status bit 10) |
| lvl_empty_flag | output | 1 | Polled almost-empty flag (status bit 11) |
| fill_count | output | 6 | Number of words held, 0..32 |

## Verification
The assertions take for granted that every input is a known value at each rising edge after reset. They also assume that `cfg_data` and `push_data` matter only in cycles where their strobe is high. Push and pop may arrive together in any combination, including on a full or empty store, and the direction may change at any time. The stimulus keeps within these bounds by driving every input to a defined value at the falling edge. Its directed phases walk the count across both levels, past full and past empty. A long randomized phase then mixes direction, activity, strobes and configuration.

// File: rtl/fdq_pkg.sv
package fdq_pkg;
    localparam int LVL_W = 5;

    typedef enum logic [2:0] {
        LV_IDLE,
        LV_RX_WAIT,
        LV_RX_DMA,
        LV_RX_FLAG,
        LV_TX_WAIT,
        LV_TX_DMA,
        LV_TX_FLAG
    } lv_state_e;

    typedef struct packed {
        logic             rx_dma_en;
        logic [LVL_W-1:0] af_lvl;
        logic             tx_dma_en;
        logic [LVL_W-1:0] ae_lvl;
    } buf_cfg_t;
endpackage

// File: rtl/fdq_cfg.sv
module fdq_cfg
    import fdq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_data,
    output buf_cfg_t    cfg_q
);
    // bits 14:13 and 6:5 carry no function (R3)
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_data[14:13], cfg_data[6:5]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.rx_dma_en <= 1'b0;
            cfg_q.af_lvl    <= '1;
            cfg_q.tx_dma_en <= 1'b0;
            cfg_q.ae_lvl    <= '0;
        end else if (cfg_wr) begin
            cfg_q.rx_dma_en <= cfg_data[15];
            cfg_q.af_lvl    <= cfg_data[12:8];
            cfg_q.tx_dma_en <= cfg_data[7];
            cfg_q.ae_lvl    <= cfg_data[4:0];
        end
    end
endmodule

// File: rtl/fdq_store.sv
module fdq_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             underrun,
    output logic [CW-1:0]    count_q
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic             push_ok, pop_ok;

    assign push_ok  = push && (count_q != CW'(DEPTH));
    assign pop_ok   = pop && (count_q != '0);
    assign pop_data = mem_q[rd_ptr_q];
    assign underrun = pop && (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                mem_q[wr_ptr_q] <= push_data;
                wr_ptr_q        <= wr_ptr_q + 1'b1;
            end
            if (pop_ok) rd_ptr_q <= rd_ptr_q + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count_q == CW'(DEPTH)) |=> (count_q == CW'(DEPTH) && $stable(wr_ptr_q)));

    a_r10_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count_q == '0) |=> (count_q == '0 && $stable(rd_ptr_q)));
endmodule

// File: rtl/fdq_level_fsm.sv
module fdq_level_fsm
    import fdq_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  buf_cfg_t      cfg_i,
    input  logic          dir_rx,
    input  logic          xfer_active,
    output logic          rx_dreq,
    output logic          tx_dreq,
    output logic          lvl_full_flag,
    output logic          lvl_empty_flag
);
    lv_state_e st_q, st_d;
    logic      idle_c, af_hit, ae_hit;

    assign idle_c = !xfer_active && (count_i == '0);
    assign af_hit = count_i > CW'(cfg_i.af_lvl);
    assign ae_hit = count_i < CW'(cfg_i.ae_lvl);

    always_comb begin
        if (idle_c)
            st_d = LV_IDLE;
        else if (dir_rx)
            st_d = !af_hit ? LV_RX_WAIT : (cfg_i.rx_dma_en ? LV_RX_DMA : LV_RX_FLAG);
        else
            st_d = !ae_hit ? LV_TX_WAIT : (cfg_i.tx_dma_en ? LV_TX_DMA : LV_TX_FLAG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LV_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        rx_dreq        = 1'b0;
        tx_dreq        = 1'b0;
        lvl_full_flag  = 1'b0;
        lvl_empty_flag = 1'b0;
        unique case (st_q)
            LV_RX_DMA:  rx_dreq        = 1'b1;
            LV_RX_FLAG: lvl_full_flag  = 1'b1;
            LV_TX_DMA:  tx_dreq        = 1'b1;
            LV_TX_FLAG: lvl_empty_flag = 1'b1;
            default: ;
        endcase
    end

    a_r11_one_service: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_dreq, tx_dreq, lvl_full_flag, lvl_empty_flag}));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && count_i == '0) |=> !(rx_dreq || tx_dreq || lvl_full_flag || lvl_empty_flag));

    a_r4_rx_request: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rx && xfer_active && count_i > CW'(cfg_i.af_lvl) && cfg_i.rx_dma_en) |=> (rx_dreq && !lvl_full_flag));

    a_r6_tx_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rx && xfer_active && count_i < CW'(cfg_i.ae_lvl) && cfg_i.tx_dma_en) |=> (tx_dreq && !lvl_empty_flag));
endmodule

// File: rtl/fifo_level_dreq.sv
module fifo_level_dreq
    import fdq_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [15:0]      cfg_data,
    input  logic             dir_rx,
    input  logic             xfer_active,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             underrun,
    output logic             rx_dreq,
    output logic             tx_dreq,
    output logic             lvl_full_flag,
    output logic             lvl_empty_flag,
    output logic [CW-1:0]    fill_count
);
    buf_cfg_t cfg_q;

    fdq_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .cfg_q    (cfg_q)
    );

    fdq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .underrun  (underrun),
        .count_q   (fill_count)
    );

    fdq_level_fsm #(.CW(CW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .count_i        (fill_count),
        .cfg_i          (cfg_q),
        .dir_rx         (dir_rx),
        .xfer_active    (xfer_active),
        .rx_dreq        (rx_dreq),
        .tx_dreq        (tx_dreq),
        .lvl_full_flag  (lvl_full_flag),
        .lvl_empty_flag (lvl_empty_flag)
    );
endmodule

// File: tb/fifo_level_dreq_bench.sv
module fifo_level_dreq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_data = '0;
    logic        dir_rx = 1'b0;
    logic        xfer_active = 1'b0;
    logic        push = 1'b0;
    logic [15:0] push_data = '0;
    logic        pop = 1'b0;
    logic [15:0] pop_data;
    logic        underrun, rx_dreq, tx_dreq, lvl_full_flag, lvl_empty_flag;
    logic [5:0]  fill_count;

    always #5 clk = ~clk;

    fifo_level_dreq u_fifo_level_dreq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .dir_rx(dir_rx), .xfer_active(xfer_active), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .underrun(underrun), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq),
        .lvl_full_flag(lvl_full_flag), .lvl_empty_flag(lvl_empty_flag),
        .fill_count(fill_count)
    );

    // reference model
    logic [15:0] m_q[$];
    logic [15:0] m_shadow [32];
    int          m_rp, m_wp;
    bit          m_rxen, m_txen;
    int          m_af, m_ae;
    bit          e_rx, e_tx, e_ff, e_fe, e_idle;
    int          n_checks = 0, n_fail = 0;
    string       cnt_tag = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            for (int i = 0; i < 32; i++) m_shadow[i] = '0;
            m_rp = 0; m_wp = 0;
            m_rxen = 0; m_txen = 0; m_af = 31; m_ae = 0;
            {e_rx, e_tx, e_ff, e_fe} = '0;
            e_idle = 1;
        end else begin
            int cnt;
            bit pok, ook;
            cnt = m_q.size();
            {e_rx, e_tx, e_ff, e_fe} = '0;
            e_idle = !xfer_active && cnt == 0;
            if (!e_idle) begin
                if (dir_rx) begin
                    if (cnt > m_af) begin
                        if (m_rxen) e_rx = 1; else e_ff = 1;
                    end
                end else if (cnt < m_ae) begin
                    if (m_txen) e_tx = 1; else e_fe = 1;
                end
            end
            pok = push && cnt < 32;
            ook = pop && cnt > 0;
            if (ook) begin
                void'(m_q.pop_front());
                m_rp = (m_rp + 1) % 32;
            end
            if (pok) begin
                m_q.push_back(push_data);
                m_shadow[m_wp] = push_data;
                m_wp = (m_wp + 1) % 32;
            end
            if (cfg_wr) begin
                m_rxen = cfg_data[15];
                m_af   = int'(cfg_data[12:8]);
                m_txen = cfg_data[7];
                m_ae   = int'(cfg_data[4:0]);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk(cnt_tag, int'(fill_count), m_q.size());
            chk(e_idle ? "R8 rx_dreq idle" : "R4 rx_dreq (R3 fields)", int'(rx_dreq), int'(e_rx));
            chk(e_idle ? "R8 full flag idle" : "R5 full flag", int'(lvl_full_flag), int'(e_ff));
            chk(e_idle ? "R8 tx_dreq idle" : "R6 tx_dreq (R3 fields)", int'(tx_dreq), int'(e_tx));
            chk(e_idle ? "R8 empty flag idle" : "R7 empty flag", int'(lvl_empty_flag), int'(e_fe));
            chk("R11 at most one service output",
                int'($countones({rx_dreq, tx_dreq, lvl_full_flag, lvl_empty_flag}) <= 1), 1);
            chk("R10 underrun", int'(underrun), int'(pop && m_q.size() == 0));
            if (pop) begin
                if (m_q.size() > 0) chk("R1 pop order", int'(pop_data), int'(m_q[0]));
                else                chk("R10 stale head", int'(pop_data), int'(m_shadow[m_rp]));
            end
        end
    end

    logic [15:0] word_ctr = 16'h1000;

    task automatic cyc(input bit p, input bit o, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_wr = 0;
            push = p; pop = o;
            push_data = word_ctr;
            word_ctr = word_ctr + 16'h0013;
        end
    endtask

    task automatic set_cfg(input logic [15:0] v);
        @(negedge clk);
        push = 0; pop = 0;
        cfg_wr = 1; cfg_data = v;
    endtask

    bit done = 0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R3, R8): outputs quiet, count 0
        chk("R8 reset rx_dreq", int'(rx_dreq), 0);
        chk("R2 reset count", int'(fill_count), 0);
        rst_n = 1;
        cyc(0, 0, 2);
        // R10 pop after reset: stale zero head
        cyc(0, 1, 2);
        // tx direction, DMA on, ae=4 (bit7 en, bits4:0 level); bits 14:13,6:5 set to test ignore (R3)
        xfer_active = 1; dir_rx = 0;
        set_cfg(16'h60E4);
        cyc(1, 0, 6);
        cyc(0, 0, 2);
        // R7 polled mode, ae=8
        set_cfg(16'h0008);
        cyc(0, 0, 3);
        // R9 overfill
        cnt_tag = "R9";
        cyc(1, 0, 36);
        cyc(1, 1, 3);
        cyc(0, 0, 2);
        cnt_tag = "R2";
        // R4 rx direction, af=4, DMA
        dir_rx = 1;
        set_cfg(16'h8400);
        cyc(0, 1, 30);
        cyc(0, 0, 2);
        // R5 polled
        set_cfg(16'h0400);
        cyc(0, 0, 2);
        cyc(0, 1, 5);
        // R10 underrun pops
        cyc(0, 1, 4);
        cyc(1, 1, 3);
        cyc(1, 0, 8);
        cyc(1, 1, 5);
        // R8 idle drain
        xfer_active = 0;
        cyc(0, 1, 40);
        cyc(0, 0, 3);
        // randomized mix
        for (int k = 0; k < 4000; k++) begin
            if (($urandom % 50) == 0) begin
                @(negedge clk);
                push = 0; pop = 0;
                cfg_wr = 1; cfg_data = 16'($urandom);
            end else begin
                @(negedge clk);
                cfg_wr = 0;
                if (($urandom % 40) == 0) dir_rx = ~dir_rx;
                if (($urandom % 60) == 0) xfer_active = ~xfer_active;
                push = ($urandom % 3) != 0 ? dir_rx ^ 1'(($urandom % 4) == 0) : 1'b0;
                pop  = ($urandom % 2) == 0;
                push_data = 16'($urandom);
            end
        end
        cyc(0, 0, 3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule